// File: doc/BRIEF.md
# I2C Byte Buffer Handshake Controller

This block links a processor register port to a bit-level I2C shift engine through a single 8-bit byte buffer. When the block transmits, software loads the buffer and sets a transfer-byte control bit. The block then hands the byte to the engine, and the control bit clears itself when the engine takes the byte. When the block receives, the engine's byte is copied into the buffer once the acknowledge cycle finishes. Software reads the byte, selects ACK or NACK for the next byte, and re-arms transfer-byte.

After each byte, the block holds SCL low through a stretch request to the engine until software has serviced the buffer. This applies in both directions. There is one exception in transmit: if a STOP is pending and no transfer-byte request is present, the stretch is dropped so the engine can finish the STOP. Two sticky flags, transmit-empty and receive-full, drive interrupt lines through their enable bits. A read-only monitor word reports synchronized copies of the SCL and SDA pin levels, so software can spot a hung bus.

Top module: `i2cbuf_ctrl`

## Requirements
- R1: Register map, selected by `reg_addr`: 0 is CTRL, 1 is STAT, 2 is DATA and 3 is MON. CTRL holds bit0 transfer-byte, bit1 NACK select, bit2 direction (1 = transmit), bit3 transmit-empty enable and bit4 receive-full enable. STAT holds bit0 transmit-empty and bit1 receive-full. DATA holds the buffer in bits [7:0]. All other read bits, including DATA bits [31:8], read as zero.
- R2: After reset, CTRL, STAT and DATA read 0, and `eng_load`, `eng_stretch`, `irq_txe` and `irq_rxf` are low.
- R3: `eng_load` is high while transfer-byte is set and the engine is idle. In transmit, `eng_tx_data` equals the buffer during that cycle. Transfer-byte reads back 0 after the engine has accepted the byte.
- R4: In transmit, an `eng_done` from a busy engine sets the transmit-empty flag on the next edge. `irq_txe` equals that flag ANDed with its enable.
- R5: In transmit, `eng_stretch` rises after a completed byte and stays high until transfer-byte is written as 1. It is low in the cycle after that write.
- R6: In transmit, a pending STOP (`eng_stop_pend`) with transfer-byte clear keeps `eng_stretch` low.
- R7: In receive, an `eng_done` from a busy engine copies `eng_rx_data` into the buffer and sets the receive-full flag. `irq_rxf` equals that flag ANDed with its enable.
- R8: In receive, `eng_stretch` stays high and `eng_load` stays low until the buffer has been read and transfer-byte is set. Both change in the cycle after the later of the two actions. `eng_ack_ctl` follows the NACK select bit.
- R9: Writing 1 to a STAT bit clears that flag. Writing 0 leaves it unchanged.
- R10: MON bit0 shows SDA and bit1 shows SCL, each passed through a two-flop synchronizer. A pin change becomes visible two clock edges later, and MON reads 3 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of DATA counts as servicing a received byte |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data (low byte) |
| reg_rdata | output | 32 | Read data for the selected register |
| eng_load | output | 1 | Engine may start the next byte this cycle |
| eng_tx_data | output | 8 | Byte to shift out |
| eng_ack_ctl | output | 1 | 1 sends NACK after a received byte |
| eng_stretch | output | 1 | Request to hold SCL low |
| eng_done | input | 1 | Byte plus acknowledge cycle finished |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_stop_pend | input | 1 | A STOP is due next |
| scl_pin | input | 1 | Raw SCL level |
| sda_pin | input | 1 | Raw SDA level |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_rxf | output | 1 | Receive-full interrupt |

## Verification
The bench's main target is the release of the stretch in receive mode. There it sets transfer-byte before reading the buffer. A design that released on transfer-byte alone would let a new byte overwrite unread data. The bench also waits idle cycles with the stretch held, to catch a stretch that drops early. It places a pending STOP against transfer-byte, because a design that ignored the STOP would hang the bus. It reads MON one edge too early to catch a missing synchronizer stage, and writes STAT with the other bit set to catch a clear that hits the wrong flag.

// File: rtl/i2cbuf_pkg.sv
package i2cbuf_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_DATA = 2'd2,
    RA_MON  = 2'd3
  } reg_addr_e;

  localparam int CB_XFER = 0;
  localparam int CB_NACK = 1;
  localparam int CB_DIR  = 2;
  localparam int CB_TXIE = 3;
  localparam int CB_RXIE = 4;
  localparam int CTRL_BITS = 5;

  localparam int SB_TXE = 0;
  localparam int SB_RXF = 1;

  // sticky flag: set wins over clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic irq_gate(logic flag, logic en);
    return flag & en;
  endfunction
endpackage

// File: rtl/i2cbuf_sync.sv
module i2cbuf_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL[b]}};
      else        sh <= {sh[STAGES-2:0], d[b]};
    end
    assign q[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/i2cbuf_hs.sv
module i2cbuf_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_tx,
  input  logic xfer,
  input  logic stop_pend,
  input  logic eng_done,
  input  logic rx_read,
  output logic load,
  output logic stretch,
  output logic done_tx,
  output logic done_rx,
  output logic rx_unread
);
  logic busy_q, pend_q, unread_q;
  logic done_ok;

  assign done_ok = eng_done & busy_q;
  assign done_tx = done_ok & dir_tx;
  assign done_rx = done_ok & ~dir_tx;
  assign load    = xfer & ~busy_q & (dir_tx | ~unread_q);

  always_comb begin
    if (dir_tx) stretch = pend_q & ~xfer & ~stop_pend;
    else        stretch = pend_q & (unread_q | ~xfer);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      unread_q <= 1'b0;
    end else begin
      if (load)         busy_q <= 1'b1;
      else if (done_ok) busy_q <= 1'b0;
      if (done_ok)      pend_q <= 1'b1;
      else if (load)    pend_q <= 1'b0;
      unread_q <= i2cbuf_pkg::flag_next(unread_q, done_rx, rx_read);
    end
  end

  assign rx_unread = unread_q;
endmodule

// File: rtl/i2cbuf_regs.sv
module i2cbuf_regs import i2cbuf_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              eng_load,
  input  logic              done_tx,
  input  logic              done_rx,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              xfer_q,
  output logic              nack_q,
  output logic              dir_q,
  output logic              txie_q,
  output logic              rxie_q,
  output logic              txe_q,
  output logic              rxf_q,
  output logic [DATA_W-1:0] data_q
);
  logic wr_ctrl, wr_stat, wr_data;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_data = reg_wr && (reg_addr == RA_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= 1'b0;
      nack_q <= 1'b0;
      dir_q  <= 1'b0;
      txie_q <= 1'b0;
      rxie_q <= 1'b0;
      txe_q  <= 1'b0;
      rxf_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) begin
        xfer_q <= reg_wdata[CB_XFER];
        nack_q <= reg_wdata[CB_NACK];
        dir_q  <= reg_wdata[CB_DIR];
        txie_q <= reg_wdata[CB_TXIE];
        rxie_q <= reg_wdata[CB_RXIE];
      end else if (eng_load) begin
        xfer_q <= 1'b0;
      end
      txe_q <= flag_next(txe_q, done_tx, wr_stat & reg_wdata[SB_TXE]);
      rxf_q <= flag_next(rxf_q, done_rx, wr_stat & reg_wdata[SB_RXF]);
      if (done_rx)      data_q <= eng_rx_data;
      else if (wr_data) data_q <= reg_wdata;
    end
  end
endmodule

// File: rtl/i2cbuf_ctrl.sv
module i2cbuf_ctrl import i2cbuf_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              eng_load,
  output logic [DATA_W-1:0] eng_tx_data,
  output logic              eng_ack_ctl,
  output logic              eng_stretch,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_stop_pend,
  input  logic              scl_pin,
  input  logic              sda_pin,
  output logic              irq_txe,
  output logic              irq_rxf
);
  localparam int MON_W = 2;

  logic xfer_w, nack_w, dir_w, txie_w, rxie_w, txe_w, rxf_w;
  logic [DATA_W-1:0] data_w;
  logic done_tx_w, done_rx_w, rx_unread_w;
  logic data_rd_w, ctrl_wr_w;
  logic [MON_W-1:0] mon_w;

  assign data_rd_w = reg_rd && (reg_addr == RA_DATA);
  assign ctrl_wr_w = reg_wr && (reg_addr == RA_CTRL);

  i2cbuf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .eng_load(eng_load), .done_tx(done_tx_w),
    .done_rx(done_rx_w), .eng_rx_data(eng_rx_data), .xfer_q(xfer_w),
    .nack_q(nack_w), .dir_q(dir_w), .txie_q(txie_w), .rxie_q(rxie_w),
    .txe_q(txe_w), .rxf_q(rxf_w), .data_q(data_w)
  );

  i2cbuf_hs u_hs (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_w), .xfer(xfer_w),
    .stop_pend(eng_stop_pend), .eng_done(eng_done), .rx_read(data_rd_w),
    .load(eng_load), .stretch(eng_stretch), .done_tx(done_tx_w),
    .done_rx(done_rx_w), .rx_unread(rx_unread_w)
  );

  i2cbuf_sync #(.WIDTH(MON_W), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_pin, sda_pin}), .q(mon_w)
  );

  assign eng_tx_data = data_w;
  assign eng_ack_ctl = nack_w;
  assign irq_txe     = irq_gate(txe_w, txie_w);
  assign irq_rxf     = irq_gate(rxf_w, rxie_w);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata[CTRL_BITS-1:0] = {rxie_w, txie_w, dir_w, nack_w, xfer_w};
      RA_STAT: reg_rdata[1:0] = {rxf_w, txe_w};
      RA_DATA: reg_rdata[DATA_W-1:0] = data_w;
      default: reg_rdata[MON_W-1:0] = mon_w;
    endcase
  end
endmodule

// File: rtl/i2cbuf_chk.sv
module i2cbuf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eng_load,
  input logic        eng_stretch,
  input logic        eng_stop_pend,
  input logic        irq_txe,
  input logic        irq_rxf,
  input logic [31:0] reg_rdata,
  input logic [7:0]  reg_rdata_lo_unused_guard,
  input logic        xfer,
  input logic        dir_tx,
  input logic        txie,
  input logic        rxie,
  input logic        unread,
  input logic        done_tx,
  input logic        done_rx,
  input logic        txe,
  input logic        rxf,
  input logic        ctrl_wr
);
  logic guard_ok;
  assign guard_ok = (reg_rdata_lo_unused_guard == reg_rdata[7:0]);

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    guard_ok && (reg_rdata[31:8] == 24'd0)); // R1
  AST_XFER_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load && !ctrl_wr |=> !xfer); // R3
  AST_LOAD_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load |-> xfer); // R3
  AST_TXE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done_tx |=> txe); // R4
  AST_TXE_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txe |-> (txe && txie)); // R4
  AST_STOP_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    dir_tx && eng_stop_pend && !xfer |-> !eng_stretch); // R6
  AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done_rx |=> rxf); // R7
  AST_RXF_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxf |-> (rxf && rxie)); // R7
  AST_RX_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_tx && unread && !eng_load |-> eng_stretch || !eng_stretch && !unread); // R8
  AST_RX_NO_LOAD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load && !dir_tx |-> !unread); // R8
endmodule

bind i2cbuf_ctrl i2cbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_load(eng_load), .eng_stretch(eng_stretch),
  .eng_stop_pend(eng_stop_pend), .irq_txe(irq_txe), .irq_rxf(irq_rxf),
  .reg_rdata(reg_rdata), .reg_rdata_lo_unused_guard(reg_rdata[7:0]),
  .xfer(xfer_w), .dir_tx(dir_w), .txie(txie_w), .rxie(rxie_w),
  .unread(rx_unread_w), .done_tx(done_tx_w), .done_rx(done_rx_w),
  .txe(txe_w), .rxf(rxf_w), .ctrl_wr(ctrl_wr_w)
);

// File: tb/i2cbuf_ctrl_tb.sv
module i2cbuf_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_MON = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic eng_load, eng_ack_ctl, eng_stretch, irq_txe, irq_rxf;
  logic [7:0] eng_tx_data;
  logic eng_done = 0, eng_stop_pend = 0, scl_pin = 1, sda_pin = 1;
  logic [7:0] eng_rx_data = 0;
  int checks = 0, errors = 0;

  i2cbuf_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_load(eng_load), .eng_tx_data(eng_tx_data), .eng_ack_ctl(eng_ack_ctl),
    .eng_stretch(eng_stretch), .eng_done(eng_done), .eng_rx_data(eng_rx_data),
    .eng_stop_pend(eng_stop_pend), .scl_pin(scl_pin), .sda_pin(sda_pin),
    .irq_txe(irq_txe), .irq_rxf(irq_rxf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ctrl(logic x, logic n, logic d, logic ti, logic ri);
    return {3'b000, ri, ti, d, n, x};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic done_pulse(logic [7:0] b);
    @(negedge clk); eng_done = 1; eng_rx_data = b;
    @(negedge clk); eng_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all-requirements act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1c2b));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R2 reset state
    rd(A_CTRL, v); chk("R2 ctrl", v, 0);
    rd(A_STAT, v); chk("R2 stat", v, 0);
    rd(A_DATA, v); chk("R2 data", v, 0);
    chk("R2 outs", {eng_load, eng_stretch, irq_txe, irq_rxf}, 0);
    rd(A_MON, v); chk("R10 mon reset", v, 3);
    // R10 synchronizer latency
    @(negedge clk); sda_pin = 0; scl_pin = 1;
    rd(A_MON, v); chk("R10 mon one edge", v, 3);
    rd(A_MON, v); chk("R10 mon two edges", v, 2);
    @(negedge clk); sda_pin = 1; scl_pin = 0;
    repeat (3) @(negedge clk);
    rd(A_MON, v); chk("R10 mon scl", v, 1);
    scl_pin = 1;
    // R1 upper bits zero
    wr(A_DATA, 8'hA5);
    rd(A_DATA, v); chk("R1 data", v, 32'h0000_00A5);
    // R3 transmit load
    wr(A_DATA, 8'h3C);
    wr(A_CTRL, ctrl(1, 0, 1, 1, 0));
    chk("R3 load", {eng_load, eng_tx_data}, {1'b1, 8'h3C});
    @(negedge clk);
    chk("R3 load gone", eng_load, 0);
    rd(A_CTRL, v); chk("R3 xfer clears", v, ctrl(0, 0, 1, 1, 0));
    // R4 / R5
    done_pulse(8'h00);
    chk("R4 irq txe", irq_txe, 1);
    chk("R5 stretch", eng_stretch, 1);
    repeat (3) @(negedge clk);
    chk("R5 stretch held", eng_stretch, 1);
    wr(A_DATA, 8'h5A);
    chk("R5 stretch after data only", eng_stretch, 1);
    // R6 stop pending
    @(negedge clk); eng_stop_pend = 1; #1;
    chk("R6 stop no stretch", eng_stretch, 0);
    @(negedge clk); eng_stop_pend = 0; #1;
    chk("R6 stretch back", eng_stretch, 1);
    wr(A_CTRL, ctrl(1, 0, 1, 1, 0));
    chk("R5 release", {eng_stretch, eng_load, eng_tx_data}, {1'b0, 1'b1, 8'h5A});
    @(negedge clk);
    done_pulse(8'h00);
    // R4 disabled irq, R9 clear
    wr(A_CTRL, ctrl(0, 0, 1, 0, 0));
    chk("R4 irq masked", irq_txe, 0);
    wr(A_STAT, 8'h02);
    rd(A_STAT, v); chk("R9 other flag kept", v, 1);
    wr(A_STAT, 8'h01);
    rd(A_STAT, v); chk("R9 flag cleared", v, 0);
    wr(A_CTRL, ctrl(1, 0, 1, 0, 0));
    @(negedge clk);
    done_pulse(8'h00);
    // R7 / R8 receive
    wr(A_CTRL, ctrl(1, 1, 0, 0, 1));
    chk("R8 rx load ack", {eng_load, eng_ack_ctl}, 2'b11);
    @(negedge clk);
    done_pulse(8'hC3);
    chk("R7 irq rxf", irq_rxf, 1);
    chk("R8 rx stretch", eng_stretch, 1);
    wr(A_CTRL, ctrl(1, 0, 0, 0, 1));
    chk("R8 xfer without read", {eng_stretch, eng_load}, 2'b10);
    rd(A_DATA, v); chk("R7 rx data", v, 32'hC3);
    chk("R8 release after read", {eng_stretch, eng_load, eng_ack_ctl}, 3'b010);
    @(negedge clk);
    done_pulse(8'h77);
    rd(A_DATA, v); chk("R7 rx data 2", v, 32'h77);
    wr(A_STAT, 8'h03);
    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [7:0] b;
      logic tx, n;
      int w;
      b = 8'($urandom); tx = 1'($urandom); n = 1'($urandom); w = int'($urandom % 4);
      if (tx) begin
        wr(A_DATA, b);
        chk("R5 rand hold", eng_stretch, 1);
        wr(A_CTRL, ctrl(1, 0, 1, 1, 1));
        chk("R3 rand load", {eng_load, eng_tx_data}, {1'b1, b});
        @(negedge clk);
        repeat (w) @(negedge clk);
        chk("R5 rand busy", eng_stretch, 0);
        done_pulse(8'h00);
        chk("R4 rand irq", irq_txe, 1);
        wr(A_STAT, 8'h03);
        chk("R9 rand clr", irq_txe, 0);
      end else begin
        wr(A_CTRL, ctrl(1, n, 0, 1, 1));
        chk("R8 rand load", {eng_load, eng_ack_ctl}, {1'b1, n});
        @(negedge clk);
        done_pulse(b);
        chk("R7 rand irq", {irq_rxf, eng_stretch}, 2'b11);
        repeat (w) @(negedge clk);
        chk("R8 rand hold", eng_stretch, 1);
        rd(A_DATA, v); chk("R7 rand data", v, {24'd0, b});
        wr(A_STAT, 8'h03);
        chk("R9 rand clr", irq_rxf, 0);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule